// File: doc/BRIEF.md
# Three-Lane Round-Robin Population Counter

This block accepts a 48-bit word on every clock from a stream that never pauses, and returns the number of set bits in each word. The count logic is written to take three clock cycles. To keep full throughput, the block holds three identical counting lanes and deals incoming words to them in strict rotation. Each lane therefore sees a new word only once in three cycles. While it holds that word, it has a full three-cycle window to produce the count. A merge stage collects the finished counts in the same order the words arrived. The total latency is a constant four cycles.

Lane timing comes from one-hot circular enable rings clocked by the single system clock. No derived clock is used. The ring is replicated, so each group of enable loads has a nearby driver, and every copy is loaded with the same start pattern so that all copies step together. A start-phase parameter chooses which lane takes the first word after reset. A keep flag travels with each word. Only kept words raise the output valid flag four cycles later. Discarded words still pass through their lane slot and are dropped at the output.

Top module: `tri_lane_popcount`

## Requirements
- R1: With reset released, a word presented with `din_keep`=1 on every cycle produces `dout_valid`=1 on every cycle once the pipeline has filled. No cycle is lost at the rotation boundaries.
- R2: When `dout_valid` is 1, `dout` equals the number of 1 bits in the corresponding input word. This holds from 0 up to the full width of 48.
- R3: The word sampled at clock edge n is reported after clock edge n+4, so it is visible in the cycle that follows the fourth later edge. The order of results matches the order of the input words.
- R4: A word sampled with `din_keep`=0 gives `dout_valid`=0 in its output slot. It does not disturb the neighbouring results.
- R5: `rst_n` is synchronous and active low. While it is low, and for the four cycles after it is released, `dout_valid` is 0. A reset in the middle of the stream cancels every word that has not yet reached the output.
- R6: The lane enables rotate by one lane position on every cycle, so each lane captures exactly once every three cycles. Consecutive words with different counts all come out correct.
- R7: Every copy of the enable ring is one-hot on every cycle, and all copies hold the same value.
- R8: Parameter `START_PHASE` (0 to 2) names the lane that captures the first word after reset. The latency and order seen at the ports do not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | DATA_W (48) | Input word, one per clock |
| din_keep | input | 1 | 1 = deliver this word's count, 0 = discard it |
| dout | output | CNT_W (6) | Count of 1 bits in the word from four cycles earlier |
| dout_valid | output | 1 | dout holds the count of a kept word |

## Verification
The counting lanes are driven with these patterns:
- all zeros and all ones, which reach both ends of the count range;
- single set bits at the lowest and highest positions, which expose a dropped end bit in the count;
- alternating and irregular patterns, which show up mix-ups between lanes, because neighbouring results differ.

Kept and discarded words are interleaved to show that a discard removes only its own slot. A long run of distinct words passes through every lane many times and tests the rotation and the lock-step of the ring copies. A reset pulse in the middle of the stream tests the cancellation of words still in flight. A second instance with a different start phase must give the same port behaviour.

// File: rtl/tri_lane_pkg.sv
// Shared constants and helpers for the three-lane population counter.
// Assumes a fixed phase count of three; widths are derived from DATA_W.
package tri_lane_pkg;

    // Number of lanes and enable phases; the lane timing budget equals this.
    localparam int unsigned PHASES = 3;

    // Bits needed to hold a count from 0 up to w inclusive.
    function automatic int unsigned cnt_width(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/tri_lane_ring.sv
// One copy of the rotating phase-enable ring.
// Does: holds a one-hot vector that moves up one bit per clock and wraps.
// Assumes: every copy in the block gets the same START and reset, so the
// copies stay in lock-step without any cross-connection.
module tri_lane_ring #(
    parameter int unsigned PHASES = 3,
    parameter int unsigned START  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PHASES-1:0] en
);

    localparam logic [PHASES-1:0] SEED = {{(PHASES-1){1'b0}}, 1'b1} << START;

    // Reload the seed on reset, otherwise rotate toward the next lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= SEED;
        end else begin
            en <= {en[PHASES-2:0], en[PHASES-1]};
        end
    end

endmodule

// File: rtl/tri_lane_unit.sv
// One counting lane.
// Does: on its enable it captures a new word and keep flag, and at the same
// time registers the count of the word it captured on its previous enable.
// Assumes: enable pulses arrive exactly PHASES cycles apart, so the path from
// hold_q to res is given PHASES cycles to settle.
module tri_lane_unit #(
    parameter int unsigned DATA_W = 48,
    parameter int unsigned CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    input  logic              keep,
    output logic [CNT_W-1:0]  res,
    output logic              res_keep,
    output logic              res_vld
);

    logic [DATA_W-1:0] hold_q;
    logic              hold_keep;
    logic              hold_vld;
    logic [CNT_W-1:0]  ones;

    // Slow path: add up the set bits of the held word.
    always_comb begin
        ones = '0;
        for (int b = 0; b < DATA_W; b++) begin
            ones = ones + CNT_W'(hold_q[b]);
        end
    end

    // Capture the next word and register the previous count on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_keep <= 1'b0;
            hold_vld  <= 1'b0;
            res       <= '0;
            res_keep  <= 1'b0;
            res_vld   <= 1'b0;
        end else if (en) begin
            hold_q    <= din;
            hold_keep <= keep;
            hold_vld  <= 1'b1;
            res       <= ones;
            res_keep  <= hold_keep;
            res_vld   <= hold_vld;
        end
    end

endmodule

// File: rtl/tri_lane_merge.sv
// Result merge.
// Does: remembers which lane was enabled on the last edge; that lane has just
// registered a fresh result. It forwards that result and raises the output
// valid for kept words only.
// Assumes: phase is one-hot and in step with the lane enables.
module tri_lane_merge #(
    parameter int unsigned PHASES = 3,
    parameter int unsigned CNT_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PHASES-1:0]       phase,
    input  logic [PHASES*CNT_W-1:0] res_bus,
    input  logic [PHASES-1:0]       keep_bus,
    input  logic [PHASES-1:0]       vld_bus,
    output logic [CNT_W-1:0]        dout,
    output logic                    dout_valid
);

    logic [PHASES-1:0] sel_q;
    logic [CNT_W-1:0]  pick_res;
    logic              pick_ok;

    // Delay the phase by one cycle so it points at the lane that just finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= phase;
        end
    end

    // AND-OR select of the fresh lane result and its keep/valid pair.
    always_comb begin
        pick_res = '0;
        pick_ok  = 1'b0;
        for (int i = 0; i < PHASES; i++) begin
            if (sel_q[i]) begin
                pick_res = pick_res | res_bus[i*CNT_W +: CNT_W];
                pick_ok  = pick_ok | (keep_bus[i] & vld_bus[i]);
            end
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout       <= pick_res;
            dout_valid <= pick_ok;
        end
    end

endmodule

// File: rtl/tri_lane_popcount.sv
// Top: three-lane round-robin population counter.
// Does: deals one word per clock to PHASES lanes in rotation. Each lane
// enable comes from a nearby copy of the phase ring. Results are merged
// back in order with a fixed latency of four edges.
// Assumes: input never stalls; 1 <= RING_COPIES; START_PHASE < PHASES.
module tri_lane_popcount
    import tri_lane_pkg::*;
#(
    parameter int unsigned DATA_W      = 48,
    parameter int unsigned RING_COPIES = 4,
    parameter int unsigned START_PHASE = 0,
    localparam int unsigned CNT_W      = cnt_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_keep,
    output logic [CNT_W-1:0]  dout,
    output logic              dout_valid
);

    localparam int unsigned MERGE_COPY = RING_COPIES - 1;

    logic [RING_COPIES*PHASES-1:0] ring_bus;
    logic [PHASES*CNT_W-1:0]       res_bus;
    logic [PHASES-1:0]             keep_bus;
    logic [PHASES-1:0]             vld_bus;

    // Replicated enable rings, each loaded with the same start pattern.
    for (genvar c = 0; c < RING_COPIES; c++) begin : g_ring
        tri_lane_ring #(
            .PHASES (PHASES),
            .START  (START_PHASE)
        ) u_ring (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ring_bus[c*PHASES +: PHASES])
        );
    end

    // Lanes: lane i takes its enable bit from ring copy (i mod RING_COPIES).
    for (genvar i = 0; i < PHASES; i++) begin : g_lane
        localparam int unsigned COPY = i % RING_COPIES;
        tri_lane_unit #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ring_bus[COPY*PHASES + i]),
            .din      (din),
            .keep     (din_keep),
            .res      (res_bus[i*CNT_W +: CNT_W]),
            .res_keep (keep_bus[i]),
            .res_vld  (vld_bus[i])
        );
    end

    // Merge, timed by the last ring copy.
    tri_lane_merge #(
        .PHASES (PHASES),
        .CNT_W  (CNT_W)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (ring_bus[MERGE_COPY*PHASES +: PHASES]),
        .res_bus    (res_bus),
        .keep_bus   (keep_bus),
        .vld_bus    (vld_bus),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

endmodule

// File: rtl/tri_lane_chk.sv
// Property checker for tri_lane_popcount, attached by bind below.
// Watches the ports and the concatenated enable-ring copies.
module tri_lane_chk
    import tri_lane_pkg::*;
#(
    parameter int unsigned DATA_W      = 48,
    parameter int unsigned RING_COPIES = 4,
    parameter int unsigned START_PHASE = 0,
    localparam int unsigned CNT_W      = cnt_width(DATA_W)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [DATA_W-1:0]             din,
    input logic                          din_keep,
    input logic [CNT_W-1:0]              dout,
    input logic                          dout_valid,
    input logic [RING_COPIES*PHASES-1:0] rings
);

    // R7
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rings[PHASES-1:0]));

    // R7
    ring_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rings == {RING_COPIES{rings[PHASES-1:0]}});

    // R6
    ring_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rings[PHASES-1:0] ==
            {$past(rings[PHASES-2:0]), $past(rings[PHASES-1])});

    // R8
    start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> rings[START_PHASE]);

    // R5
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !dout_valid);

    // R2 R3
    count_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (32'(dout) == $countones($past(din, 5))) && $past(din_keep, 5));

    // R4
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(din_keep, 5) |-> !dout_valid);

    // R1
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) &&
         $past(rst_n, 4) && $past(rst_n, 5) && $past(din_keep, 5)) |-> dout_valid);

endmodule

bind tri_lane_popcount tri_lane_chk #(
    .DATA_W      (DATA_W),
    .RING_COPIES (RING_COPIES),
    .START_PHASE (START_PHASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .din_keep   (din_keep),
    .dout       (dout),
    .dout_valid (dout_valid),
    .rings      (ring_bus)
);

// File: tb/sim_tri_lane_popcount.sv
// Bench: drives one word per clock into two instances (start phase 0 and 2)
// and compares each output slot with a count computed here.
module sim_tri_lane_popcount;

    localparam int unsigned PERIOD = 10;
    localparam int unsigned DW     = 48;
    localparam int unsigned CW     = 6;
    localparam int unsigned HIST   = 4096;
    localparam int unsigned NVEC   = 12;

    // Each entry: {keep, word}
    localparam logic [DW:0] VEC [NVEC] = '{
        {1'b1, 48'h0000_0000_0000},
        {1'b1, 48'hFFFF_FFFF_FFFF},
        {1'b1, 48'h0000_0000_0001},
        {1'b1, 48'h8000_0000_0000},
        {1'b1, 48'hAAAA_AAAA_AAAA},
        {1'b0, 48'hFFFF_FFFF_FFFF},
        {1'b1, 48'h0F0F_0000_F0F0},
        {1'b1, 48'h1234_5678_9ABC},
        {1'b0, 48'h5555_5555_5555},
        {1'b1, 48'hFFFF_FFFF_FFFE},
        {1'b1, 48'h7FFF_0000_0001},
        {1'b1, 48'hDEAD_BEEF_CAFE}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] din;
    logic          din_keep;
    logic [CW-1:0] dout0, dout1;
    logic          vld0, vld1;

    int errors = 0;
    int checks = 0;
    int n      = 0;
    string sec = "R5";

    logic [DW-1:0] h_d [HIST];
    logic          h_k [HIST];
    logic          h_r [HIST];

    always #(PERIOD/2) clk = ~clk;

    tri_lane_popcount #(.DATA_W(DW), .RING_COPIES(4), .START_PHASE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .din_keep(din_keep),
        .dout(dout0), .dout_valid(vld0)
    );

    tri_lane_popcount #(.DATA_W(DW), .RING_COPIES(2), .START_PHASE(2)) u1 (
        .clk(clk), .rst_n(rst_n), .din(din), .din_keep(din_keep),
        .dout(dout1), .dout_valid(vld1)
    );

    task automatic judge(input string tag, input logic v, input logic [CW-1:0] d,
                         input logic ev, input int ed);
        checks++;
        if (v !== ev || (ev && 32'(d) != ed)) begin
            errors++;
            $display("FAIL %s edge %0d: valid=%0b dout=%0d expected valid=%0b dout=%0d",
                     tag, n, v, d, ev, ed);
        end
    endtask

    // One clock: apply inputs, record them at the edge, check after it.
    task automatic step(input logic r, input logic [DW-1:0] d, input logic k);
        logic ev;
        int   ed;
        string tag;
        rst_n = r; din = d; din_keep = k;
        @(posedge clk);
        n++;
        h_d[n] = d; h_k[n] = k; h_r[n] = r;
        @(negedge clk);
        ev = 1'b0; ed = 0; tag = "R5";
        if (n >= 5) begin
            ev = h_r[n-4] && h_r[n-3] && h_r[n-2] && h_r[n-1] && h_r[n] && h_k[n-4];
            ed = $countones(h_d[n-4]);
            if (!(h_r[n-4] && h_r[n-3] && h_r[n-2] && h_r[n-1] && h_r[n])) tag = "R5";
            else if (!h_k[n-4]) tag = "R4";
            else tag = "R2 R3";
        end
        judge({sec, " ", tag}, vld0, dout0, ev, ed);
        judge({sec, " R8 ", tag}, vld1, dout1, ev, ed);
    endtask

    initial begin
        for (int i = 0; i < HIST; i++) begin
            h_d[i] = '0; h_k[i] = 1'b0; h_r[i] = 1'b0;
        end
        rst_n = 1'b0; din = '0; din_keep = 1'b1;
        // R5: reset state, keep high so only reset can hold valid low
        sec = "R5";
        for (int i = 0; i < 4; i++) step(1'b0, 48'hFFFF_FFFF_FFFF, 1'b1);
        // Table walk, R2 R3 R4
        sec = "R2";
        for (int i = 0; i < int'(NVEC); i++) step(1'b1, VEC[i][DW-1:0], VEC[i][DW]);
        // R4: alternating keep with distinct neighbours
        sec = "R4";
        for (int i = 0; i < 9; i++) step(1'b1, 48'h1 << (i * 5), i[0]);
        // R1 R6 R7: long unbroken kept stream of distinct words
        sec = "R1 R6 R7";
        begin
            logic [DW-1:0] lf = 48'hACE1_2468_0F0F;
            for (int i = 0; i < 40; i++) begin
                lf = {lf[46:0], lf[47] ^ lf[46] ^ lf[20] ^ lf[19]};
                step(1'b1, lf, 1'b1);
            end
        end
        // R5: one-cycle reset in the middle of a kept stream
        sec = "R5 midstream";
        step(1'b1, 48'h0000_00FF_0000, 1'b1);
        step(1'b1, 48'h0000_0F00_0000, 1'b1);
        step(1'b0, 48'hFFFF_0000_0000, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b1, 48'h3 << i, 1'b1);
        // Drain with discarded words
        sec = "R4 drain";
        for (int i = 0; i < 6; i++) step(1'b1, 48'hFFFF_FFFF_FFFF, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule